// File: doc/BRIEF.md
# Single-Source Interrupt Gate

This block watches one external interrupt line and turns a chosen condition on it into a latched pending flag. It then raises a single request toward a parent interrupt controller while that flag is set and the source is unmasked. The raw line first passes through a synchronizer. A detector then applies one of four trigger modes, two level modes and two edge modes. The reset mode is active-low level.

Software reaches the block through a small single-cycle register bus. It has three registers: control, pending and enable. Reads return data one cycle after the address is presented. The pending flag is cleared by writing a one, and the same write serves as the acknowledge in edge modes and as the end-of-interrupt in level modes. A parameter picks between two register layouts, which differ only in where the enable register sits.

Top module: `nmi_gate_ctrl`

## Requirements
- R1: After reset the control, pending and enable registers read as zero, and `irq_o` is low.
- R2: Control bits [1:0] select the trigger: 0 is level low, 1 is falling edge, 2 is level high, 3 is rising edge. The control register is at offset 0x00.
- R3: In an edge mode the pending flag sets only on the selected edge. It stays set after the line returns, and the opposite edge does not set it.
- R4: In a level mode the pending flag is set on every cycle the selected level is present. A clear while the level is still active therefore has no lasting effect.
- R5: Writing a value with bit 0 set to the pending register at offset 0x04 clears the flag. Writing a value with bit 0 at 0 leaves the flag unchanged. The flag reads back in bit 0.
- R6: When a trigger event and a clear write fall in the same cycle, the pending flag ends up set.
- R7: Enable bit 0 unmasks the source. `irq_o` is high exactly when pending and enable are both 1. The pending flag reads back while the source is masked.
- R8: Control bits above [1:0] are plain read/write storage. They read back as written, and rewriting the mode field with the same upper bits keeps those bits.
- R9: Reads of an unmapped offset return zero. Writes to an unmapped offset change no register.
- R10: `bus_rdata_o` shows the register at the address presented in the previous cycle.
- R11: The raw line passes through two synchronizer flops. A change on `raw_irq_i` cannot set pending before the third rising clock edge after it, and an edge sets pending at that edge.
- R12: With `LAYOUT` = 0 the enable register is at offset 0x08. With `LAYOUT` = 1 it is at offset 0x34, and the other of those two offsets is unmapped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_irq_i | input | 1 | Asynchronous external interrupt line |
| bus_addr_i | input | ADDR_W | Register byte offset |
| bus_we_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Registered read data |
| irq_o | output | 1 | Interrupt request to the parent controller |

## Verification
The hardest case to reach from the ports is the collision of a trigger event with a clear write in the same clock cycle. The event surfaces only after the synchronizer, so the input edge and the bus write have to be offset by a known number of cycles. The bench changes the line on a falling clock edge and lets two rising edges pass. It then presents the write-one-to-clear in the cycle in which the detector fires, and afterwards expects the flag to be set. The same cycle counting is used to show that the request rises no earlier than the third edge after the line moves.

// File: rtl/nmi_gate_pkg.sv
package nmi_gate_pkg;

  typedef enum logic [1:0] {
    TRIG_LEVEL_LOW  = 2'd0,
    TRIG_EDGE_FALL  = 2'd1,
    TRIG_LEVEL_HIGH = 2'd2,
    TRIG_EDGE_RISE  = 2'd3
  } trig_mode_e;

  localparam int unsigned OFF_CTRL = 32'h00;
  localparam int unsigned OFF_PEND = 32'h04;

  // enable register offset per layout variant
  function automatic int unsigned en_offset(input int unsigned layout);
    return (layout == 0) ? 32'h08 : 32'h34;
  endfunction

endpackage

// File: rtl/nmi_sync.sv
module nmi_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain_q <= RST_VAL;
        else     chain_q <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain_q <= {STAGES{RST_VAL}};
        else     chain_q <= {chain_q[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/nmi_trig_detect.sv
module nmi_trig_detect
  import nmi_gate_pkg::*;
#(
  parameter logic IDLE_LEVEL = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       level_i,
  input  trig_mode_e mode_i,
  output logic       set_o
);

  logic prev_q;
  logic rise, fall;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= IDLE_LEVEL;
    else     prev_q <= level_i;
  end

  assign rise = level_i & ~prev_q;
  assign fall = ~level_i & prev_q;

  always_comb begin
    unique case (mode_i)
      TRIG_LEVEL_LOW:  set_o = ~level_i;
      TRIG_EDGE_FALL:  set_o = fall;
      TRIG_LEVEL_HIGH: set_o = level_i;
      TRIG_EDGE_RISE:  set_o = rise;
      default:         set_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/nmi_regs.sv
module nmi_regs
  import nmi_gate_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned EN_OFF = 32'h08
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              set_i,
  output logic [DATA_W-1:0] rdata_o,
  output trig_mode_e        mode_o,
  output logic              pend_o,
  output logic              en_o
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(OFF_PEND);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(EN_OFF);

  logic [DATA_W-1:0] ctrl_q;
  logic              pend_q;
  logic              en_q;
  logic [DATA_W-1:0] rd_next;
  logic              hit_ctrl, hit_pend, hit_en;
  logic              clr_req;

  assign hit_ctrl = (addr_i == A_CTRL);
  assign hit_pend = (addr_i == A_PEND);
  assign hit_en   = (addr_i == A_EN);
  assign clr_req  = we_i & hit_pend & wdata_i[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      en_q   <= 1'b0;
    end else if (we_i) begin
      if (hit_ctrl) ctrl_q <= wdata_i;
      if (hit_en)   en_q   <= wdata_i[0];
    end
  end

  // set has priority over a simultaneous clear
  always_ff @(posedge clk) begin
    if (rst)          pend_q <= 1'b0;
    else if (set_i)   pend_q <= 1'b1;
    else if (clr_req) pend_q <= 1'b0;
  end

  always_comb begin
    rd_next = '0;
    if (hit_ctrl)      rd_next = ctrl_q;
    else if (hit_pend) rd_next[0] = pend_q;
    else if (hit_en)   rd_next[0] = en_q;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else     rdata_o <= rd_next;
  end

  assign mode_o = trig_mode_e'(ctrl_q[1:0]);
  assign pend_o = pend_q;
  assign en_o   = en_q;

endmodule

// File: rtl/nmi_gate_ctrl.sv
module nmi_gate_ctrl
  import nmi_gate_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned LAYOUT      = 0,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic        IDLE_LEVEL  = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              raw_irq_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o
);

  localparam int unsigned EN_OFF = en_offset(LAYOUT);

  logic       line_sync;
  logic       set_evt;
  logic       pend_q;
  logic       en_q;
  trig_mode_e mode;

  nmi_sync #(
    .STAGES (SYNC_STAGES),
    .RST_VAL(IDLE_LEVEL)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .din (raw_irq_i),
    .dout(line_sync)
  );

  nmi_trig_detect #(
    .IDLE_LEVEL(IDLE_LEVEL)
  ) u_det (
    .clk    (clk),
    .rst    (rst),
    .level_i(line_sync),
    .mode_i (mode),
    .set_o  (set_evt)
  );

  nmi_regs #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .EN_OFF(EN_OFF)
  ) u_regs (
    .clk    (clk),
    .rst    (rst),
    .addr_i (bus_addr_i),
    .we_i   (bus_we_i),
    .wdata_i(bus_wdata_i),
    .set_i  (set_evt),
    .rdata_o(bus_rdata_o),
    .mode_o (mode),
    .pend_o (pend_q),
    .en_o   (en_q)
  );

  // both operands come straight from flops
  assign irq_o = pend_q & en_q;

endmodule

// File: rtl/nmi_gate_ctrl_chk.sv
module nmi_gate_ctrl_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned EN_OFF = 32'h08
) (
  input logic              clk,
  input logic              rst,
  input logic              irq_o,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              bus_we_i,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic [DATA_W-1:0] bus_rdata_o,
  input logic              pend_q,
  input logic              en_q,
  input logic              set_evt
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(32'h00);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(32'h04);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(EN_OFF);

  logic clr_wr;
  assign clr_wr = bus_we_i && (bus_addr_i == A_PEND) && bus_wdata_i[0];

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!pend_q && !en_q && !irq_o && bus_rdata_o == '0));

  assert_clear_wins_alone_R5: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && !set_evt) |=> !pend_q);

  assert_pend_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !clr_wr) |=> pend_q);

  assert_set_wins_R6: assert property (@(posedge clk) disable iff (rst)
    set_evt |=> pend_q);

  assert_mask_write_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_we_i && bus_addr_i == A_EN && !bus_wdata_i[0]) |=> !irq_o);

  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_addr_i != A_CTRL && bus_addr_i != A_PEND && bus_addr_i != A_EN)
      |=> bus_rdata_o == '0);

endmodule

bind nmi_gate_ctrl nmi_gate_ctrl_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .EN_OFF(EN_OFF)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .irq_o      (irq_o),
  .bus_addr_i (bus_addr_i),
  .bus_we_i   (bus_we_i),
  .bus_wdata_i(bus_wdata_i),
  .bus_rdata_o(bus_rdata_o),
  .pend_q     (pend_q),
  .en_q       (en_q),
  .set_evt    (set_evt)
);

// File: tb/tb_nmi_gate_ctrl.sv
`timescale 1ns/1ps
module tb_nmi_gate_ctrl;

  localparam logic [7:0] A_CTRL = 8'h00;
  localparam logic [7:0] A_PEND = 8'h04;
  localparam logic [7:0] A_EN0  = 8'h08;
  localparam logic [7:0] A_EN1  = 8'h34;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        raw = 1'b1;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata_b;
  logic        irq, irq_b;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  nmi_gate_ctrl #(.LAYOUT(0)) dut (
    .clk(clk), .rst(rst), .raw_irq_i(raw), .bus_addr_i(addr),
    .bus_we_i(we), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  nmi_gate_ctrl #(.LAYOUT(1)) dut_b (
    .clk(clk), .rst(rst), .raw_irq_i(raw), .bus_addr_i(addr),
    .bus_we_i(we), .bus_wdata_i(wdata), .bus_rdata_o(rdata_b), .irq_o(irq_b)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0; addr = 8'hF0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; we = 1'b0;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic settle_clear(input logic lvl, input logic [31:0] mode);
    raw = lvl;
    idle(4);
    wr(A_CTRL, mode);
    idle(3);
    wr(A_PEND, 32'h1);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_CTRL, v); chk("R1 ctrl", v, 0);
    rd(A_PEND, v); chk("R1 pend", v, 0);
    rd(A_EN0, v);  chk("R1 en", v, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_rising();
    logic [31:0] v;
    settle_clear(1'b0, 32'h3);
    rd(A_PEND, v); chk("R3 rise idle", v, 0);
    raw = 1'b1; idle(4);
    rd(A_PEND, v); chk("R2 R3 rise sets", v, 1);
    raw = 1'b0; idle(4);
    rd(A_PEND, v); chk("R3 held after return", v, 1);
    wr(A_PEND, 32'h1); raw = 1'b0; idle(4);
    rd(A_PEND, v); chk("R3 falling ignored", v, 0);
  endtask

  task automatic t_falling();
    logic [31:0] v;
    settle_clear(1'b1, 32'h1);
    raw = 1'b0; idle(4);
    rd(A_PEND, v); chk("R2 R3 fall sets", v, 1);
    wr(A_PEND, 32'h1); idle(2);
    rd(A_PEND, v); chk("R3 no reassert on low", v, 0);
    raw = 1'b1; idle(4);
    rd(A_PEND, v); chk("R3 rising ignored", v, 0);
  endtask

  task automatic t_level_high();
    logic [31:0] v;
    settle_clear(1'b0, 32'h2);
    rd(A_PEND, v); chk("R2 lvl high idle", v, 0);
    raw = 1'b1; idle(4);
    rd(A_PEND, v); chk("R2 R4 lvl high sets", v, 1);
    wr(A_PEND, 32'h1); idle(1);
    rd(A_PEND, v); chk("R4 reasserts while high", v, 1);
    raw = 1'b0; idle(4); wr(A_PEND, 32'h1);
    rd(A_PEND, v); chk("R4 clears after release", v, 0);
  endtask

  task automatic t_level_low();
    logic [31:0] v;
    settle_clear(1'b1, 32'h0);
    rd(A_PEND, v); chk("R2 lvl low idle", v, 0);
    raw = 1'b0; idle(4);
    rd(A_PEND, v); chk("R2 R4 lvl low sets", v, 1);
    wr(A_PEND, 32'h1);
    rd(A_PEND, v); chk("R4 reasserts while low", v, 1);
    raw = 1'b1; idle(4); wr(A_PEND, 32'h1);
    rd(A_PEND, v); chk("R4 low released", v, 0);
  endtask

  task automatic t_w1c_zero();
    logic [31:0] v;
    settle_clear(1'b0, 32'h3);
    raw = 1'b1; idle(4);
    wr(A_PEND, 32'hFFFF_FFFE);
    rd(A_PEND, v); chk("R5 write zero keeps", v, 1);
    wr(A_PEND, 32'h1);
    rd(A_PEND, v); chk("R5 write one clears", v, 0);
  endtask

  task automatic t_set_wins();
    logic [31:0] v;
    settle_clear(1'b0, 32'h3);
    raw = 1'b1; idle(4); raw = 1'b0; idle(4);
    @(negedge clk); raw = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); addr = A_PEND; wdata = 32'h1; we = 1'b1;
    @(negedge clk); we = 1'b0; addr = 8'hF0;
    rd(A_PEND, v); chk("R6 set beats clear", v, 1);
  endtask

  task automatic t_sync_latency();
    settle_clear(1'b0, 32'h3);
    wr(A_EN0, 32'h1);
    @(negedge clk); raw = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); chk("R11 not before third edge", irq, 0);
    @(negedge clk); chk("R11 set at third edge", irq, 1);
    wr(A_EN0, 32'h0); wr(A_PEND, 32'h1);
  endtask

  task automatic t_enable();
    logic [31:0] v;
    settle_clear(1'b0, 32'h3);
    wr(A_EN0, 32'h0);
    raw = 1'b1; idle(4);
    chk("R7 masked irq low", irq, 0);
    rd(A_PEND, v); chk("R7 pending visible masked", v, 1);
    wr(A_EN0, 32'h1);
    rd(A_EN0, v); chk("R7 enable reads", v, 1);
    chk("R7 irq high", irq, 1);
    wr(A_PEND, 32'h1);
    chk("R7 irq drops on clear", irq, 0);
    wr(A_EN0, 32'h0);
  endtask

  task automatic t_ctrl_storage();
    logic [31:0] v;
    raw = 1'b1; idle(4);
    wr(A_CTRL, 32'hA5A5_5A5C);
    rd(A_CTRL, v); chk("R8 upper bits stored", v, 32'hA5A5_5A5C);
    wr(A_CTRL, {v[31:2], 2'b11});
    rd(A_CTRL, v); chk("R8 rmw keeps upper", v, 32'hA5A5_5A5F);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    wr(A_CTRL, 32'h0000_0003); wr(A_EN0, 32'h0);
    wr(8'h0C, 32'hFFFF_FFFF); wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h0C, v); chk("R9 unmapped read", v, 0);
    rd(8'h10, v); chk("R9 unmapped read 2", v, 0);
    rd(A_CTRL, v); chk("R9 ctrl untouched", v, 3);
    rd(A_EN0, v);  chk("R9 enable untouched", v, 0);
  endtask

  task automatic t_read_latency();
    @(negedge clk); addr = A_CTRL; we = 1'b0;
    @(negedge clk); addr = A_EN0;
    chk("R10 data of previous address", rdata, 3);
    @(negedge clk);
    chk("R10 next address", rdata, 0);
  endtask

  task automatic t_layout();
    wr(A_EN0, 32'h1);
    @(negedge clk); addr = A_EN0;
    @(negedge clk);
    chk("R12 layout0 enable at 0x08", rdata, 1);
    chk("R12 layout1 0x08 unmapped", rdata_b, 0);
    wr(A_EN0, 32'h0);
    wr(A_EN1, 32'h1);
    @(negedge clk); addr = A_EN1;
    @(negedge clk);
    chk("R12 layout1 enable at 0x34", rdata_b, 1);
    chk("R12 layout0 0x34 unmapped", rdata, 0);
    wr(A_EN1, 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_rising();
    t_falling();
    t_level_high();
    t_level_low();
    t_w1c_zero();
    t_set_wins();
    t_sync_latency();
    t_enable();
    t_ctrl_storage();
    t_unmapped();
    t_read_latency();
    t_layout();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule